// File: doc/BRIEF.md
# Command Block List Walker

This block runs a chain of command blocks kept in a shared memory of 16-bit words. It reaches that memory through a single request/grant port that can read or write. After a start pulse it takes the current block and marks it busy. It then reads the command word. Commands that need outside work go to an external responder as a code and a block address, and the walker waits there for a done pulse. The link-test command is handled by the walker itself. No-op, dump and diagnose complete at once. The walker then writes the completion status and reads the 32-bit link to the next block. Finally it acts on the three flag bits of the command word: stop, suspend and interrupt.

Each block has this layout: a status word at byte offset 0, the command word at offset 2, and the link at offset 4. The link's low halfword is at offset 4 and its high halfword at offset 6. A link of all ones or all zeros counts as null. The walker keeps a command-unit state and a sticky CX bit, and it raises a level interrupt that stays up until it is acknowledged.

Top module: `cmd_list_seq`

## Requirements
- R1: After reset, cu_state_o is 0 (idle), cx_o and irq_o are low, and neither mem_req_o nor cmd_valid_o is asserted.
- R2: A start_i pulse in the waiting state has two cases. If the held pointer is null, it loads start_ptr_i. If the new pointer is non-null, cu_state_o becomes 2 (active). The first memory access writes 0x4000 to the block address (offset 0), and the second reads offset 2.
- R3: While mem_req_o is high and mem_gnt_i is low, the request, address, write enable and write data stay unchanged. Read data is taken in the grant cycle.
- R4: After a command's work, the walker writes 0xA000 to offset 0. It then reads offset 4 (low link half) and offset 6 (high link half). The next block is entered at the pointer {high, low}.
- R5: Command word bits [2:0] select the operation. Codes 1 to 4 appear on cmd_code_o, with cmd_ptr_o set to the block address. cmd_valid_o and the code hold until cmd_done_i, and no memory access is made meanwhile. Codes 0, 6 and 7 are not dispatched and complete with 0xA000.
- R6: Code 5 is not dispatched. It writes 0x8000 to offset 8 when link_up_i is high, or 0x0000 when it is low, and then writes 0x0000 to offset 10.
- R7: Command word bit 15 ends the walk after the block. The held pointer becomes null, cu_state_o returns to 0, and the link target is never accessed.
- R8: A link of 0x00000000 or 0xFFFFFFFF ends the walk the same way as bit 15.
- R9: Command word bit 14 stops the walk after the block with cu_state_o at 1 (suspended), and the link is kept. The next start_i resumes at the kept link and ignores start_ptr_i.
- R10: Each completed block sets cx_o to its command word bit 13. When bit 13 is set, irq_o is also set. irq_o then stays high until irq_ack_i, and a new set wins over an acknowledge in the same cycle.
- R11: start_i has no effect while a list is being walked.
- R12: cu_state_o only takes the codes 0 (idle), 1 (suspended) and 2 (active).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or resume pulse |
| start_ptr_i | input | 32 | First block address, used when the held pointer is null |
| link_up_i | input | 1 | Link state reported by the link-test command |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_gnt_i | input | 1 | Access accepted this cycle |
| mem_rdata_i | input | 16 | Read data, valid in the grant cycle |
| cmd_valid_o | output | 1 | Command waiting for the external responder |
| cmd_code_o | output | 3 | Operation code |
| cmd_ptr_o | output | 32 | Address of the command block |
| cmd_done_i | input | 1 | Responder has finished the command |
| cu_state_o | output | 2 | 0 idle, 1 suspended, 2 active |
| cx_o | output | 1 | Interrupt flag of the last completed block |
| irq_o | output | 1 | Interrupt request, sticky |
| irq_ack_i | input | 1 | Clears irq_o |

## Verification
The checker watches several rules on every cycle:
- the request stays stable until it is granted;
- dispatch holds until done, with no memory traffic during dispatch;
- only codes 1 to 4 are ever dispatched;
- the legal state codes;
- an interrupt only rises together with CX, and only falls after an acknowledge.

The directed scenarios cover what only shows in memory and in ordering:
- the busy/complete status values and the exact access order;
- link following and the two null encodings;
- the link-test values for both link states;
- resuming after a suspend;
- a start pulse being ignored during a walk.

// File: rtl/cmd_list_seq_pkg.sv
package cmd_list_seq_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    CU_IDLE   = 2'd0,
    CU_SUSP   = 2'd1,
    CU_ACTIVE = 2'd2
  } cu_state_e;

  typedef enum logic [3:0] {
    ST_WAIT, ST_MARK, ST_FETCH, ST_EXEC, ST_LT_LO, ST_LT_HI,
    ST_DONE, ST_LINK_LO, ST_LINK_HI
  } seq_state_e;

  localparam logic [WORD_W-1:0] STAT_BUSY    = 16'h4000;
  localparam logic [WORD_W-1:0] STAT_DONE_OK = 16'hA000;
  localparam logic [WORD_W-1:0] LINK_UP_VAL  = 16'h8000;

  localparam int FLAG_EOL  = 15;
  localparam int FLAG_SUSP = 14;
  localparam int FLAG_INTR = 13;

  localparam logic [CODE_W-1:0] OP_NOP      = 3'd0;
  localparam logic [CODE_W-1:0] OP_TX       = 3'd4;
  localparam logic [CODE_W-1:0] OP_LINKTEST = 3'd5;

  // flags plus operation code, kept from the command word
  typedef struct packed {
    logic              eol;
    logic              susp;
    logic              intr;
    logic [CODE_W-1:0] code;
  } cmd_fields_t;

  function automatic logic ptr_is_null(input logic [2*WORD_W-1:0] p);
    return (p == '0) || (&p);
  endfunction
endpackage

// File: rtl/cmd_list_seq_decode.sv
module cmd_list_seq_decode
  import cmd_list_seq_pkg::*;
(
  input  cmd_fields_t       fields_i,
  output logic [CODE_W-1:0] code_o,
  output logic              eol_o,
  output logic              susp_o,
  output logic              intr_o,
  output logic              ext_o,
  output logic              linktest_o
);
  assign code_o     = fields_i.code;
  assign eol_o      = fields_i.eol;
  assign susp_o     = fields_i.susp;
  assign intr_o     = fields_i.intr;
  // codes 1..4 need the external responder
  assign ext_o      = (fields_i.code != OP_NOP) && (fields_i.code <= OP_TX);
  assign linktest_o = (fields_i.code == OP_LINKTEST);
endmodule

// File: rtl/cmd_list_seq_addr.sv
module cmd_list_seq_addr
  import cmd_list_seq_pkg::*;
#(
  parameter int PTR_W    = 32,
  parameter int STAT_OFS = 0,
  parameter int CMD_OFS  = 2,
  parameter int LINK_OFS = 4,
  parameter int TEST_OFS = 8
) (
  input  seq_state_e         state_i,
  input  logic [PTR_W-1:0]   blk_ptr_i,
  input  logic               link_up_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [PTR_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o
);
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int LINK_HI_OFS = LINK_OFS + WORD_BYTES;
  localparam int TEST_HI_OFS = TEST_OFS + WORD_BYTES;

  logic [PTR_W-1:0] ofs;

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    ofs         = '0;
    unique case (state_i)
      ST_MARK: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = STAT_BUSY;
        ofs         = PTR_W'(STAT_OFS);
      end
      ST_FETCH:   ofs = PTR_W'(CMD_OFS);
      ST_LT_LO: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = link_up_i ? LINK_UP_VAL : '0;
        ofs         = PTR_W'(TEST_OFS);
      end
      ST_LT_HI: begin
        mem_we_o = 1'b1;
        ofs      = PTR_W'(TEST_HI_OFS);
      end
      ST_DONE: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = STAT_DONE_OK;
        ofs         = PTR_W'(STAT_OFS);
      end
      ST_LINK_LO: ofs = PTR_W'(LINK_OFS);
      ST_LINK_HI: ofs = PTR_W'(LINK_HI_OFS);
      default:    mem_req_o = 1'b0;
    endcase
  end

  assign mem_addr_o = blk_ptr_i + ofs;
endmodule

// File: rtl/cmd_list_seq_irq.sv
module cmd_list_seq_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic intr_i,
  input  logic ack_i,
  output logic cx_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cx_o  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (upd_i) cx_o <= intr_i;
      if (upd_i && intr_i) irq_o <= 1'b1;
      else if (ack_i)      irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_list_seq.sv
module cmd_list_seq
  import cmd_list_seq_pkg::*;
#(
  parameter int PTR_W    = 32,
  parameter int STAT_OFS = 0,
  parameter int CMD_OFS  = 2,
  parameter int LINK_OFS = 4,
  parameter int TEST_OFS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PTR_W-1:0]   start_ptr_i,
  input  logic               link_up_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [PTR_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o,
  input  logic               mem_gnt_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               cmd_valid_o,
  output logic [CODE_W-1:0]  cmd_code_o,
  output logic [PTR_W-1:0]   cmd_ptr_o,
  input  logic               cmd_done_i,
  output logic [1:0]         cu_state_o,
  output logic               cx_o,
  output logic               irq_o,
  input  logic               irq_ack_i
);
  localparam logic [PTR_W-1:0] NULL_PTR = '1;

  seq_state_e        state_q;
  cu_state_e         cu_q;
  logic [PTR_W-1:0]  cur_ptr_q;
  cmd_fields_t       cmd_q;
  logic [WORD_W-1:0] link_lo_q;

  // decode the fresh word while fetching, the stored one afterwards
  cmd_fields_t       dec_in;
  logic [CODE_W-1:0] dec_code;
  logic              dec_eol, dec_susp, dec_intr, dec_ext, dec_lt;

  assign dec_in = (state_q == ST_FETCH) ?
                  cmd_fields_t'({mem_rdata_i[FLAG_EOL], mem_rdata_i[FLAG_SUSP],
                                 mem_rdata_i[FLAG_INTR], mem_rdata_i[CODE_W-1:0]}) :
                  cmd_q;

  cmd_list_seq_decode i_decode (
    .fields_i   (dec_in),
    .code_o     (dec_code),
    .eol_o      (dec_eol),
    .susp_o     (dec_susp),
    .intr_o     (dec_intr),
    .ext_o      (dec_ext),
    .linktest_o (dec_lt)
  );

  cmd_list_seq_addr #(
    .PTR_W    (PTR_W),
    .STAT_OFS (STAT_OFS),
    .CMD_OFS  (CMD_OFS),
    .LINK_OFS (LINK_OFS),
    .TEST_OFS (TEST_OFS)
  ) i_addr (
    .state_i     (state_q),
    .blk_ptr_i   (cur_ptr_q),
    .link_up_i   (link_up_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  logic             blk_end;
  logic [PTR_W-1:0] next_ptr;
  logic             next_null;
  logic [PTR_W-1:0] start_sel;

  assign blk_end   = (state_q == ST_LINK_HI) && mem_gnt_i;
  assign next_ptr  = {mem_rdata_i, link_lo_q};
  assign next_null = dec_eol || ptr_is_null(next_ptr);
  assign start_sel = ptr_is_null(cur_ptr_q) ? start_ptr_i : cur_ptr_q;

  cmd_list_seq_irq i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (blk_end),
    .intr_i (dec_intr),
    .ack_i  (irq_ack_i),
    .cx_o   (cx_o),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_WAIT;
      cu_q      <= CU_IDLE;
      cur_ptr_q <= NULL_PTR;
      cmd_q     <= '0;
      link_lo_q <= '0;
    end else begin
      unique case (state_q)
        ST_WAIT: if (start_i) begin
          if (ptr_is_null(start_sel)) begin
            cur_ptr_q <= NULL_PTR;
            cu_q      <= CU_IDLE;
          end else begin
            cur_ptr_q <= start_sel;
            cu_q      <= CU_ACTIVE;
            state_q   <= ST_MARK;
          end
        end
        ST_MARK: if (mem_gnt_i) state_q <= ST_FETCH;
        ST_FETCH: if (mem_gnt_i) begin
          cmd_q <= dec_in;
          if (dec_lt)       state_q <= ST_LT_LO;
          else if (dec_ext) state_q <= ST_EXEC;
          else              state_q <= ST_DONE;
        end
        ST_EXEC:    if (cmd_done_i) state_q <= ST_DONE;
        ST_LT_LO:   if (mem_gnt_i) state_q <= ST_LT_HI;
        ST_LT_HI:   if (mem_gnt_i) state_q <= ST_DONE;
        ST_DONE:    if (mem_gnt_i) state_q <= ST_LINK_LO;
        ST_LINK_LO: if (mem_gnt_i) begin
          link_lo_q <= mem_rdata_i;
          state_q   <= ST_LINK_HI;
        end
        ST_LINK_HI: if (mem_gnt_i) begin
          cur_ptr_q <= next_null ? NULL_PTR : next_ptr;
          if (dec_susp) begin
            cu_q    <= CU_SUSP;
            state_q <= ST_WAIT;
          end else if (next_null) begin
            cu_q    <= CU_IDLE;
            state_q <= ST_WAIT;
          end else begin
            state_q <= ST_MARK;
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  assign cmd_valid_o = (state_q == ST_EXEC);
  assign cmd_code_o  = dec_code;
  assign cmd_ptr_o   = cur_ptr_q;
  assign cu_state_o  = cu_q;
endmodule

// File: rtl/cmd_list_seq_checker.sv
module cmd_list_seq_checker #(
  parameter int PTR_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [PTR_W-1:0] mem_addr_o,
  input logic [15:0]      mem_wdata_o,
  input logic             mem_gnt_i,
  input logic             cmd_valid_o,
  input logic [2:0]       cmd_code_o,
  input logic             cmd_done_i,
  input logic [1:0]       cu_state_o,
  input logic             cx_o,
  input logic             irq_o,
  input logic             irq_ack_i
);
  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_cmd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_code_o));

  assert_cmd_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_code_o != 3'd0) && (cmd_code_o <= 3'd4));

  assert_no_mem_in_cmd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !mem_req_o);

  assert_cu_legal_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cu_state_o != 2'd3);

  assert_irq_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> cx_o);

  assert_irq_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(irq_ack_i));
endmodule

bind cmd_list_seq cmd_list_seq_checker #(.PTR_W(PTR_W)) i_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_gnt_i   (mem_gnt_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_code_o  (cmd_code_o),
  .cmd_done_i  (cmd_done_i),
  .cu_state_o  (cu_state_o),
  .cx_o        (cx_o),
  .irq_o       (irq_o),
  .irq_ack_i   (irq_ack_i)
);

// File: tb/test_cmd_list_seq.sv
module test_cmd_list_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_ptr = '0;
  logic        link_up = 1'b1;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        cmd_valid;
  logic [2:0]  cmd_code;
  logic [31:0] cmd_ptr;
  logic        cmd_done = 1'b0;
  logic [1:0]  cu_state;
  logic        cx, irq;
  logic        irq_ack = 1'b0;
  logic        gnt_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_list_seq i_cmd_list_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_ptr_i(start_ptr),
    .link_up_i(link_up), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
    .mem_rdata_i(mem_rdata), .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code),
    .cmd_ptr_o(cmd_ptr), .cmd_done_i(cmd_done), .cu_state_o(cu_state),
    .cx_o(cx), .irq_o(irq), .irq_ack_i(irq_ack)
  );

  logic [15:0] mem [512];
  assign mem_gnt   = mem_req && gnt_en;
  assign mem_rdata = mem[mem_addr[9:1]];

  int          n_tests = 0;
  int          n_fail  = 0;
  int          r3_err  = 0;
  int          resp_delay = 1;
  logic [31:0] tr_addr [64];
  logic        tr_we   [64];
  logic [15:0] tr_data [64];
  int          tr_cnt = 0;
  logic [2:0]  lg_code [16];
  logic [31:0] lg_ptr  [16];
  int          lg_cnt = 0;

  // memory writes and access trace
  initial forever begin
    @(posedge clk);
    if (mem_req && gnt_en) begin
      if (mem_we) mem[mem_addr[9:1]] <= mem_wdata;
      if (tr_cnt < 64) begin
        tr_addr[tr_cnt] <= mem_addr;
        tr_we[tr_cnt]   <= mem_we;
        tr_data[tr_cnt] <= mem_wdata;
      end
      tr_cnt <= tr_cnt + 1;
    end
  end

  // grant pattern and request-hold monitor
  initial begin
    logic [7:0]  lfsr = 8'hA5;
    logic        pend = 1'b0;
    logic [31:0] p_addr = '0;
    logic        p_we = 1'b0;
    forever begin
      @(negedge clk);
      if (pend && (!mem_req || mem_addr != p_addr || mem_we != p_we)) r3_err++;
      lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      gnt_en = lfsr[0] | lfsr[2];
      pend   = mem_req && !gnt_en;
      p_addr = mem_addr;
      p_we   = mem_we;
    end
  end

  // external command responder
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (cmd_valid && !cmd_done) begin
        if (dly <= 0) begin
          cmd_done = 1'b1;
          if (lg_cnt < 16) begin
            lg_code[lg_cnt] = cmd_code;
            lg_ptr[lg_cnt]  = cmd_ptr;
          end
          lg_cnt++;
        end else dly--;
      end else begin
        cmd_done = 1'b0;
        dly      = resp_delay;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic setw(input logic [31:0] a, input logic [15:0] v);
    mem[a[9:1]] = v;
  endtask

  function automatic logic [15:0] getw(input logic [31:0] a);
    return mem[a[9:1]];
  endfunction

  task automatic mkblk(input logic [31:0] p, input logic [15:0] cmd, input logic [31:0] link);
    setw(p, 16'h1111);
    setw(p + 2, cmd);
    setw(p + 4, link[15:0]);
    setw(p + 6, link[31:16]);
  endtask

  task automatic clear_logs();
    @(negedge clk);
    tr_cnt = 0;
    lg_cnt = 0;
  endtask

  task automatic pulse_start(input logic [31:0] p);
    @(negedge clk);
    start     = 1'b1;
    start_ptr = p;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_stop();
    int n = 0;
    while (cu_state == 2'd2 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_list(input logic [31:0] p);
    clear_logs();
    pulse_start(p);
    wait_stop();
  endtask

  task automatic t_reset();
    check("R1 cu_state", cu_state, 2'd0);
    check("R1 cx", cx, 1'b0);
    check("R1 irq", irq, 1'b0);
    check("R1 mem_req", mem_req, 1'b0);
    check("R1 cmd_valid", cmd_valid, 1'b0);
  endtask

  task automatic t_basic();
    mkblk(32'h40, 16'h0004, 32'h80);
    mkblk(32'h80, 16'h0000, 32'hC0);
    mkblk(32'hC0, 16'h8002, 32'h100);
    setw(32'h100, 16'h1234);
    run_list(32'h40);
    check("R2 first access addr", tr_addr[0], 32'h40);
    check("R2 first access write", tr_we[0], 1'b1);
    check("R2 busy value", tr_data[0], 16'h4000);
    check("R2 fetch addr", tr_addr[1], 32'h42);
    check("R2 fetch is read", tr_we[1], 1'b0);
    check("R4 status addr", tr_addr[2], 32'h40);
    check("R4 status value", tr_data[2], 16'hA000);
    check("R4 link lo addr", tr_addr[3], 32'h44);
    check("R4 link hi addr", tr_addr[4], 32'h46);
    check("R4 next block addr", tr_addr[5], 32'h80);
    check("R5 dispatch count", lg_cnt, 2);
    check("R5 dispatch code 0", lg_code[0], 3'd4);
    check("R5 dispatch ptr 0", lg_ptr[0], 32'h40);
    check("R5 dispatch code 1", lg_code[1], 3'd2);
    check("R5 dispatch ptr 1", lg_ptr[1], 32'hC0);
    check("R5 nop status", getw(32'h80), 16'hA000);
    check("R4 last status", getw(32'hC0), 16'hA000);
    check("R7 access count", tr_cnt, 15);
    check("R7 target untouched", getw(32'h100), 16'h1234);
    check("R7 cu idle", cu_state, 2'd0);
    check("R3 request held", r3_err, 0);
  endtask

  task automatic t_codes_null();
    mkblk(32'h40, 16'h0006, 32'h80);
    mkblk(32'h80, 16'h0007, 32'hFFFF_FFFF);
    run_list(32'h40);
    check("R5 code 6/7 not dispatched", lg_cnt, 0);
    check("R5 code 6 status", getw(32'h40), 16'hA000);
    check("R5 code 7 status", getw(32'h80), 16'hA000);
    check("R8 all-ones link cu idle", cu_state, 2'd0);
    check("R8 all-ones access count", tr_cnt, 10);
    mkblk(32'h40, 16'h0001, 32'h0);
    setw(32'h0, 16'h2222);
    run_list(32'h40);
    check("R8 zero link dispatch", lg_cnt, 1);
    check("R8 zero link cu idle", cu_state, 2'd0);
    check("R8 zero link untouched", getw(32'h0), 16'h2222);
  endtask

  task automatic t_linktest();
    link_up = 1'b1;
    mkblk(32'h40, 16'h8005, 32'h80);
    setw(32'h48, 16'h5555);
    setw(32'h4A, 16'h5555);
    run_list(32'h40);
    check("R6 not dispatched", lg_cnt, 0);
    check("R6 link up value", getw(32'h48), 16'h8000);
    check("R6 upper half", getw(32'h4A), 16'h0000);
    check("R6 status", getw(32'h40), 16'hA000);
    link_up = 1'b0;
    mkblk(32'h40, 16'h8005, 32'h80);
    setw(32'h48, 16'h5555);
    run_list(32'h40);
    check("R6 link down value", getw(32'h48), 16'h0000);
    link_up = 1'b1;
  endtask

  task automatic t_suspend();
    mkblk(32'h40, 16'h4003, 32'h80);
    mkblk(32'h80, 16'h8000, 32'h0);
    mkblk(32'h1C0, 16'h8000, 32'h0);
    run_list(32'h40);
    check("R9 cu suspended", cu_state, 2'd1);
    check("R9 dispatch code 3", lg_code[0], 3'd3);
    check("R9 next untouched", getw(32'h80), 16'h1111);
    run_list(32'h1C0);
    check("R9 resume first addr", tr_addr[0], 32'h80);
    check("R9 resumed status", getw(32'h80), 16'hA000);
    check("R9 start_ptr ignored", getw(32'h1C0), 16'h1111);
    check("R9 cu idle after end", cu_state, 2'd0);
  endtask

  task automatic t_irq();
    mkblk(32'h40, 16'h2000, 32'h80);
    mkblk(32'h80, 16'h8000, 32'h0);
    run_list(32'h40);
    check("R10 cx cleared by later block", cx, 1'b0);
    check("R10 irq sticky", irq, 1'b1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R10 irq acked", irq, 1'b0);
    mkblk(32'h40, 16'hA000, 32'h80);
    run_list(32'h40);
    check("R10 cx set", cx, 1'b1);
    check("R10 irq set", irq, 1'b1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R10 irq acked again", irq, 1'b0);
  endtask

  task automatic t_start_ignored();
    resp_delay = 20;
    mkblk(32'h40, 16'h0001, 32'h80);
    mkblk(32'h80, 16'h8000, 32'h0);
    mkblk(32'h200, 16'h8004, 32'h0);
    clear_logs();
    pulse_start(32'h40);
    repeat (8) @(negedge clk);
    pulse_start(32'h200);
    wait_stop();
    check("R11 dispatch count", lg_cnt, 1);
    check("R11 dispatch code", lg_code[0], 3'd1);
    check("R11 other block untouched", getw(32'h200), 16'h1111);
    check("R11 list completed", getw(32'h80), 16'hA000);
    resp_delay = 1;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_codes_null();
    t_linktest();
    t_suspend();
    t_irq();
    t_start_ignored();
    check("R3 request held overall", r3_err, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule